// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block turns single read or write requests from an 8-bit core into external bus cycles on a pin set where the low address byte and the data byte use the same pins at different times. Every cycle has an address clock, a strobe clock, any number of wait clocks and a final clock. During the address clock the shared byte carries the low address and a latch strobe pulses so that an external register can hold it. After that the same byte carries data. A memory/IO line and a two-bit status code describe the cycle while it runs. A slow device stretches the cycle by pulling a ready input low. An external master can take the bus with a hold/acknowledge handshake, which the block grants only between cycles.

The core side is a valid/ready request port. `req_ready` is high only while the controller is idle and no hold is requested. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The core must keep the request fields stable while `req_valid` is high and not yet taken. The response is a one-clock `rsp_valid` pulse with the read byte. This port has no back-pressure: the core must accept the response in the clock in which it appears. The shared byte is split into `ad_out`, `ad_in` and `ad_oe`. `bus_oe` enables the drivers of the address, strobe and status pins, and the pad ring outside the block acts on it.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `ale` is high for exactly the one clock after a request is taken (the address clock). In that clock `ad_oe` is 1 and `ad_out` equals the request's address bits 7..0.
- R2: `bus_ahi` equals address bits 15..8 from the address clock through the final clock of the cycle.
- R3: `iom` is 1 for an I/O cycle (`req_io`=1) and 0 for a memory cycle, from the address clock through the final clock, and 0 outside cycles.
- R4: `st` is 2'b11 for an opcode fetch (read with `req_fetch`=1), 2'b10 for any other read and 2'b01 for a write, from the address clock through the final clock. It is 2'b00 when no cycle is in progress. A write ignores `req_fetch`.
- R5: In a read, `rd_n` is 0 and `ad_oe` is 0 from the strobe clock through the final clock, `wr_n` stays 1, and `rsp_rdata` returns the `ad_in` value present at the end of the final clock.
- R6: In a write, `wr_n` is 0 and `ad_oe` is 1 with `ad_out` equal to the write data from the strobe clock through the final clock, and `rd_n` stays 1.
- R7: `ready` is sampled at the end of the strobe clock and at the end of each wait clock. Each low sample adds one wait clock in which the strobe stays low and `ale` stays low.
- R8: `req_ready` is high only in the idle state with `hold` low, and it drops in the same clock that `hold` rises.
- R9: `rsp_valid` is high for exactly one clock, the clock after the final clock. It is never high in two clocks in a row.
- R10: A `hold` that rises during a cycle does not shorten the cycle. `hlda` rises in the clock after the final clock, or one clock after `hold` is sampled while idle. While `hlda` is high, `bus_oe` and `ad_oe` are 0, `ale` is 0 and no request is taken.
- R11: `hlda` falls one clock after `hold` is sampled low. A request that is already waiting gets its address clock in the clock after that.
- R12: After reset: `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=0, `st`=2'b00, `hlda`=0, `rsp_valid`=0, `bus_oe`=1 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_fetch | input | 1 | Read is an opcode fetch |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| bus_ahi | output | 8 | High address byte |
| ad_out | output | 8 | Shared address/data byte, outgoing value |
| ad_in | input | 8 | Shared address/data byte, incoming value |
| ad_oe | output | 1 | Drive enable for the shared byte |
| bus_oe | output | 1 | Drive enable for the address, strobe and status pins |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| iom | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| st | output | 2 | Cycle status code |
| ready | input | 1 | Device ready, low inserts waits |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus granted to external master |

## Verification
A phase register in the wrong state shows at the pins in the next clock. A missing or doubled address clock appears as a wrong `ale` pulse. A phase skipped or repeated changes the number of clocks between acceptance and `rsp_valid`, or leaves a strobe low for the wrong number of clocks. A lost hold decision shows as `hlda` rising in the middle of a cycle, or as a request accepted while the bus is granted. A wrong captured request shows in the address clock on `ad_out`, `bus_ahi`, `iom` and `st`. The bench checks every clock of each cycle, so each of these faults is caught in the clock where it first appears.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_STRB  = 3'd2,
    PH_WAIT  = 3'd3,
    PH_LAST  = 3'd4,
    PH_GRANT = 3'd5
  } mbc_phase_e;

  typedef enum logic [1:0] {
    STS_NONE  = 2'b00,
    STS_WRITE = 2'b01,
    STS_READ  = 2'b10,
    STS_FETCH = 2'b11
  } mbc_sts_e;

  typedef struct packed {
    logic write;
    logic io;
    logic fetch;
  } mbc_kind_t;

  function automatic mbc_sts_e kind_to_sts(mbc_kind_t k);
    if (k.write)      return STS_WRITE;
    else if (k.fetch) return STS_FETCH;
    else              return STS_READ;
  endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  mbc_kind_t       req_kind,
  input  logic            ready_in,
  input  logic            hold_in,
  output mbc_phase_e      phase,
  output logic [AW-1:0]   cur_addr,
  output logic [DW-1:0]   cur_wdata,
  output mbc_kind_t       cur_kind
);
  mbc_phase_e phase_nx;
  logic       take;

  assign req_ready = (phase == PH_IDLE) && !hold_in;
  assign take      = req_valid && req_ready;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (hold_in) phase_nx = PH_GRANT;
                else if (req_valid) phase_nx = PH_ADDR;
      PH_ADDR:  phase_nx = PH_STRB;
      PH_STRB:  phase_nx = ready_in ? PH_LAST : PH_WAIT;
      PH_WAIT:  phase_nx = ready_in ? PH_LAST : PH_WAIT;
      PH_LAST:  phase_nx = hold_in ? PH_GRANT : PH_IDLE;
      PH_GRANT: phase_nx = hold_in ? PH_GRANT : PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_kind  <= '0;
    end else begin
      phase <= phase_nx;
      if (take) begin
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
        cur_kind  <= req_kind;
      end
    end
  end
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  mbc_phase_e      phase,
  input  logic [AW-1:0]   cur_addr,
  input  logic [DW-1:0]   cur_wdata,
  input  mbc_kind_t       cur_kind,
  output logic [HW-1:0]   ahi,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic            bus_oe,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            iom,
  output logic [1:0]      st,
  output logic            hlda
);
  logic in_cycle, strobe_ph;

  always_comb begin
    in_cycle  = (phase == PH_ADDR) || (phase == PH_STRB) ||
                (phase == PH_WAIT) || (phase == PH_LAST);
    strobe_ph = (phase == PH_STRB) || (phase == PH_WAIT) || (phase == PH_LAST);
    ale       = (phase == PH_ADDR);
    ahi       = cur_addr[AW-1:DW];
    ad_out    = ale ? cur_addr[DW-1:0] : cur_wdata;
    ad_oe     = ale || (strobe_ph && cur_kind.write);
    rd_n      = !(strobe_ph && !cur_kind.write);
    wr_n      = !(strobe_ph && cur_kind.write);
    iom       = in_cycle && cur_kind.io;
    st        = in_cycle ? kind_to_sts(cur_kind) : STS_NONE;
    hlda      = (phase == PH_GRANT);
    bus_oe    = !hlda;
  end
endmodule

// File: rtl/mbc_rdcap.sv
module mbc_rdcap
  import mbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mbc_phase_e    phase,
  input  mbc_kind_t     cur_kind,
  input  logic [DW-1:0] ad_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (phase == PH_LAST);
      if (phase == PH_LAST && !cur_kind.write) rsp_rdata <= ad_in;
    end
  end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_fetch,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [HW-1:0] bus_ahi,
  output logic [DW-1:0] ad_out,
  input  logic [DW-1:0] ad_in,
  output logic          ad_oe,
  output logic          bus_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          iom,
  output logic [1:0]    st,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);
  mbc_phase_e    phase;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  mbc_kind_t     cur_kind, req_kind;

  assign req_kind = '{write: req_write, io: req_io, fetch: req_fetch};

  mbc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_kind(req_kind),
    .ready_in(ready), .hold_in(hold), .phase(phase),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_kind(cur_kind)
  );

  mbc_pins #(.AW(AW), .DW(DW)) u_pins (
    .phase(phase), .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_kind(cur_kind),
    .ahi(bus_ahi), .ad_out(ad_out), .ad_oe(ad_oe), .bus_oe(bus_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .iom(iom), .st(st), .hlda(hlda)
  );

  mbc_rdcap #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cur_kind(cur_kind), .ad_in(ad_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/mbc_chk.sv
module mbc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       hold,
  input logic       rsp_valid,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic       bus_oe,
  input logic [1:0] st,
  input logic       hlda
);
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R1
  AST_ALE_STATUS: assert property (@(posedge clk) disable iff (!rst_n) ale |-> st != 2'b00); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R5
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R5
  AST_ACCEPT_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> ale); // R8
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) hold |-> !req_ready); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) hlda |-> (!bus_oe && !ad_oe && !ale && !req_ready)); // R10
endmodule

bind mux_bus_ctrl mbc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .hold(hold), .rsp_valid(rsp_valid), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .bus_oe(bus_oe), .st(st), .hlda(hlda)
);

// File: tb/sim_mux_bus_ctrl.sv
`timescale 1ns/1ps
module sim_mux_bus_ctrl;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_io = 0, req_fetch = 0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0;
  logic ready = 1, hold = 0;
  logic req_ready, rsp_valid, ad_oe, bus_oe, ale, rd_n, wr_n, iom, hlda;
  logic [7:0] rsp_rdata, bus_ahi, ad_out;
  logic [1:0] st;
  int total = 0, bad = 0;
  bit finished = 0;

  always #HALF clk = ~clk;

  mux_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_io(req_io), .req_fetch(req_fetch), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_ahi(bus_ahi), .ad_out(ad_out), .ad_in(ad_in),
    .ad_oe(ad_oe), .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .iom(iom), .st(st), .ready(ready), .hold(hold), .hlda(hlda)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One full cycle, checked clock by clock
  task automatic run_cycle(input bit wr, input bit io, input bit fe, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rdv, input int waits);
    logic [1:0] exp_st;
    exp_st = wr ? 2'b01 : (fe ? 2'b11 : 2'b10);
    req_valid = 1; req_write = wr; req_io = io; req_fetch = fe;
    req_addr = a; req_wdata = wd; ready = (waits == 0); ad_in = rdv;
    chk(req_ready == 1, "R8 ready idle", req_ready, 1);
    tick; req_valid = 0;
    // address clock
    chk(ale == 1, "R1 ale", ale, 1);
    chk(ad_oe == 1 && ad_out == a[7:0], "R1 addr lo", ad_out, a[7:0]);
    chk(bus_ahi == a[15:8], "R2 addr hi", bus_ahi, a[15:8]);
    chk(iom == io, "R3 iom", iom, io);
    chk(st == exp_st, "R4 status", st, exp_st);
    chk(rd_n && wr_n, "R5 strobes idle in T1", {rd_n, wr_n}, 2'b11);
    tick;
    // strobe clock
    chk(ale == 0, "R1 ale low", ale, 0);
    if (wr) begin
      chk(!wr_n && rd_n, "R6 wr strobe", {rd_n, wr_n}, 2'b10);
      chk(ad_oe && ad_out == wd, "R6 wdata", ad_out, wd);
    end else begin
      chk(!rd_n && wr_n && !ad_oe, "R5 rd strobe", {rd_n, wr_n, ad_oe}, 3'b010);
    end
    chk(bus_ahi == a[15:8] && st == exp_st && iom == io, "R2 R3 R4 hold in T2", {bus_ahi, st}, {a[15:8], exp_st});
    for (int i = 0; i < waits; i++) begin
      tick;
      if (i == waits - 1) ready = 1;
      chk((wr ? wr_n : rd_n) == 0 && !ale && !rsp_valid, "R7 wait state", {rd_n, wr_n, rsp_valid}, 0);
    end
    tick;
    // final clock
    chk((wr ? wr_n : rd_n) == 0 && !rsp_valid, "R7 final strobe", {rd_n, wr_n, rsp_valid}, 0);
    chk(bus_ahi == a[15:8] && st == exp_st && iom == io, "R2 R3 R4 hold in T3", {bus_ahi, st}, {a[15:8], exp_st});
    tick;
    chk(rsp_valid == 1, "R9 done pulse", rsp_valid, 1);
    if (!wr) chk(rsp_rdata == rdv, "R5 read data", rsp_rdata, rdv);
    chk(rd_n && wr_n && st == 2'b00 && !iom, "R4 idle after cycle", {rd_n, wr_n, st}, 4'b1100);
    tick;
    chk(rsp_valid == 0, "R9 single pulse", rsp_valid, 0);
  endtask

  task automatic test_hold_idle;
    hold = 1; #1;
    chk(req_ready == 0, "R8 hold blocks ready", req_ready, 0);
    tick;
    chk(hlda && !bus_oe && !ad_oe && !ale, "R10 grant idle", {hlda, bus_oe, ad_oe, ale}, 4'b1000);
    req_valid = 1; req_write = 0; req_io = 0; req_fetch = 0; req_addr = 16'h1234; ad_in = 8'h77;
    tick;
    chk(hlda && !ale, "R10 no start while granted", {hlda, ale}, 2'b10);
    hold = 0;
    tick;
    chk(hlda == 0 && !ale, "R11 hlda falls", {hlda, ale}, 2'b00);
    tick; req_valid = 0;
    chk(ale == 1 && ad_out == 8'h34, "R11 pending starts", {ale, ad_out}, {1'b1, 8'h34});
    tick; tick; tick;
    chk(rsp_valid && rsp_rdata == 8'h77, "R11 pending completes", rsp_rdata, 8'h77);
    tick;
  endtask

  task automatic test_hold_mid;
    req_valid = 1; req_write = 1; req_io = 1; req_fetch = 0; req_addr = 16'hBEEF; req_wdata = 8'h5A; ready = 1;
    tick; req_valid = 0; hold = 1;
    tick;
    chk(!hlda && !wr_n && ad_out == 8'h5A, "R10 cycle continues", {hlda, wr_n}, 2'b00);
    tick;
    chk(!hlda && !wr_n, "R10 final clock kept", {hlda, wr_n}, 2'b00);
    tick;
    chk(hlda && rsp_valid && !bus_oe && !ad_oe, "R10 grant after cycle", {hlda, rsp_valid, bus_oe, ad_oe}, 4'b1100);
    chk(req_ready == 0, "R10 no accept in grant", req_ready, 0);
    hold = 0;
    tick;
    chk(!hlda && bus_oe && req_ready, "R11 release", {hlda, bus_oe, req_ready}, 3'b011);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick; tick;
    chk(!ale && rd_n && wr_n && !ad_oe && st == 2'b00 && !hlda && !rsp_valid && bus_oe,
        "R12 reset outputs", {ale, rd_n, wr_n, ad_oe, st, hlda, rsp_valid, bus_oe}, 9'b011000001);
    rst_n = 1;
    tick;
    chk(req_ready == 1, "R12 ready after reset", req_ready, 1);
    run_cycle(0, 0, 0, 16'h8421, 8'h00, 8'hC3, 0);
    run_cycle(1, 1, 1, 16'h00F0, 8'hA5, 8'h00, 0);
    run_cycle(0, 0, 1, 16'h7F01, 8'h00, 8'h3C, 2);
    run_cycle(1, 0, 0, 16'hFFFF, 8'h81, 8'h00, 1);
    run_cycle(0, 1, 0, 16'h0000, 8'h00, 8'hFF, 3);
    test_hold_idle();
    test_hold_mid();
    run_cycle(0, 0, 0, 16'h5555, 8'h00, 8'h96, 0);
    finish_run();
  end
endmodule